// File: doc/BRIEF.md
# Grouped-Recency Line Buffer Allocator

This block keeps the bookkeeping for four line buffers that sit in front of a slow flash array. For each instruction or data request it checks whether one of the buffers already holds the requested line. On a hit it returns the buffer number. On a miss it names the buffer that must be refilled, which is the least-recently-used buffer among those the current configuration allows for that kind of access. The line data, the flash timing and the bus protocol all live elsewhere. The block only tracks tags, validity and recency, and returns indices.

A 2-bit configuration register selects how the buffers are grouped. They can form one shared pool, two pairs, or a group of three for instruction fetches with a single buffer for data. Speculative next-line fetches are flagged as prefetches. They may be allocated a buffer, but they never change the recency order. A prefetched line only becomes most-recently-used when a later demand access hits it. When the refill completes, the fill logic reports the buffer number and line tag through a fill strobe.

Top module: `lbuf_alloc`

## Requirements
- R1: After reset the configuration code is 11 and every buffer is invalid. The first instruction miss is given buffer 0 and the first data miss is given buffer 3.
- R2: With code 00 all four buffers form one group. Instruction and data accesses share one recency order, and either kind can hit a line filled for the other.
- R3: With code 10, instruction requests use only buffers 0 and 1, and data requests use only buffers 2 and 3.
- R4: With code 11, instruction requests use buffers 0, 1 and 2, and data requests use buffer 3 alone.
- R5: Code 01 behaves exactly like code 00.
- R6: Every request cycle (req_valid high) is answered by exactly one response in the next cycle. rsp_valid is low in any cycle that does not follow a request.
- R7: A request hits only on a valid buffer of its own group whose tag equals req_addr with the low OFF_W bits dropped. rsp_hit_idx names that buffer.
- R8: On a demand miss, rsp_victim_idx is the least-recently-used buffer of the group. That buffer becomes most-recently-used and stays invalid until it is filled.
- R9: A demand hit makes the hit buffer most-recently-used within its group, and buffers that were more recent than it age by one.
- R10: A prefetch request (req_prefetch high) does not change the recency order, whether it hits or misses. The prefetched buffer becomes most-recently-used only when a later demand request hits it.
- R11: A fill_done pulse makes buffer fill_idx valid with tag fill_tag.
- R12: A configuration write invalidates all buffers and restores the initial order, in which the lowest-numbered buffer of each group is least-recently-used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | New grouping code |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Request byte address |
| req_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_prefetch | input | 1 | Request is a speculative next-line fetch |
| fill_done | input | 1 | Refill of a buffer completed |
| fill_idx | input | 2 | Buffer that was refilled |
| fill_tag | input | ADDR_W-OFF_W | Line tag now held by that buffer |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request hit a buffer |
| rsp_hit_idx | output | 2 | Buffer that hit |
| rsp_victim_idx | output | 2 | Buffer allocated on a miss |

## Verification
The checker watches several properties on every cycle. It checks the one-cycle response timing and confirms that both hit and victim indices stay inside the requester's group. It checks that the age values of each group always form a true ranking, and that a demand access leaves its buffer at age zero. It also checks that a prefetch leaves every age untouched and that a configuration write clears all valid bits. The order in which victims are chosen across a sequence depends on history, and so does the delayed promotion of a prefetched line. The same holds for the exact grouping of codes 10 and 11 and for the aliasing of code 01. Only the bench's directed scenarios, with precomputed expected indices, can show these.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

    localparam int NBUF  = 4;
    localparam int IDX_W = 2;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [IDX_W-1:0] age_t;

    typedef enum logic [1:0] {
        CFG_POOL = 2'b00,
        CFG_RSVD = 2'b01,
        CFG_HALF = 2'b10,
        CFG_3_1  = 2'b11
    } cfg_e;

    typedef struct packed {
        logic hit;
        idx_t hit_idx;
        idx_t victim_idx;
    } rsp_t;

    // Group a buffer belongs to: 0 = instruction (or shared), 1 = data
    function automatic logic grp_of(cfg_e c, idx_t i);
        case (c)
            CFG_HALF: return i[1];
            CFG_3_1:  return (i == idx_t'(NBUF - 1));
            default:  return 1'b0;
        endcase
    endfunction

    // Group a request may use
    function automatic logic grp_for_req(cfg_e c, logic is_data);
        return (c == CFG_HALF || c == CFG_3_1) ? is_data : 1'b0;
    endfunction

    function automatic logic [IDX_W:0] grp_size(cfg_e c, logic g);
        logic [IDX_W:0] n = '0;
        for (int k = 0; k < NBUF; k++)
            if (grp_of(c, idx_t'(k)) == g) n = n + 1'b1;
        return n;
    endfunction

    // Initial rank: lowest index of a group is least-recently-used
    function automatic age_t init_age(cfg_e c, idx_t i);
        age_t n = '0;
        for (int k = 0; k < NBUF; k++)
            if (k > int'(i) && grp_of(c, idx_t'(k)) == grp_of(c, i)) n = n + 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/lbuf_tags.sv
module lbuf_tags
    import lbuf_pkg::*;
#(
    parameter int TAG_W = 28
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       alloc_en,
    input  idx_t                       alloc_idx,
    input  logic                       fill_en,
    input  idx_t                       fill_idx,
    input  logic [TAG_W-1:0]           fill_tag,
    output logic [NBUF-1:0]            valid_o,
    output logic [NBUF-1:0][TAG_W-1:0] tag_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= '0;
            tag_o   <= '0;
        end else if (flush) begin
            valid_o <= '0;
        end else begin
            for (int b = 0; b < NBUF; b++) begin
                if (alloc_en && alloc_idx == idx_t'(b)) begin
                    valid_o[b] <= 1'b0;
                end else if (fill_en && fill_idx == idx_t'(b)) begin
                    valid_o[b] <= 1'b1;
                    tag_o[b]   <= fill_tag;
                end
            end
        end
    end

endmodule

// File: rtl/lbuf_lookup.sv
module lbuf_lookup
    import lbuf_pkg::*;
#(
    parameter int TAG_W = 28
) (
    input  cfg_e                       cfg,
    input  logic                       req_grp,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic [NBUF-1:0]            valid,
    input  logic [NBUF-1:0][TAG_W-1:0] tags,
    output logic                       hit,
    output idx_t                       hit_idx
);

    logic [NBUF-1:0] match;

    for (genvar b = 0; b < NBUF; b++) begin : g_cmp
        assign match[b] = valid[b] && (tags[b] == req_tag) &&
                          (grp_of(cfg, idx_t'(b)) == req_grp);
    end

    always_comb begin
        hit_idx = '0;
        for (int b = NBUF - 1; b >= 0; b--)
            if (match[b]) hit_idx = idx_t'(b);
    end

    assign hit = |match;

endmodule

// File: rtl/lbuf_recency.sv
module lbuf_recency
    import lbuf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  cfg_e                       cfg,
    input  logic                       reinit,
    input  cfg_e                       reinit_cfg,
    input  logic                       req_grp,
    input  logic                       touch_en,
    input  idx_t                       touch_idx,
    output idx_t                       victim_idx,
    output logic [NBUF-1:0][IDX_W-1:0] ages_o
);

    logic [IDX_W:0] sz;
    age_t           lru_age;

    assign sz      = grp_size(cfg, req_grp);
    assign lru_age = age_t'(sz - 1'b1);

    always_comb begin
        victim_idx = '0;
        for (int b = 0; b < NBUF; b++)
            if (grp_of(cfg, idx_t'(b)) == req_grp && ages_o[b] == lru_age)
                victim_idx = idx_t'(b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBUF; b++) ages_o[b] <= init_age(CFG_3_1, idx_t'(b));
        end else if (reinit) begin
            for (int b = 0; b < NBUF; b++) ages_o[b] <= init_age(reinit_cfg, idx_t'(b));
        end else if (touch_en) begin
            for (int b = 0; b < NBUF; b++) begin
                if (idx_t'(b) == touch_idx)
                    ages_o[b] <= '0;
                else if (grp_of(cfg, idx_t'(b)) == grp_of(cfg, touch_idx) &&
                         ages_o[b] < ages_o[touch_idx])
                    ages_o[b] <= ages_o[b] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lbuf_alloc.sv
module lbuf_alloc
    import lbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    localparam int TAG_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_data,
    input  logic              req_prefetch,
    input  logic              fill_done,
    input  logic [1:0]        fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_hit_idx,
    output logic [1:0]        rsp_victim_idx
);

    cfg_e                       cfg_q;
    cfg_e                       cfg_new;
    logic                       req_grp;
    logic [TAG_W-1:0]           req_tag;
    logic [NBUF-1:0]            valid_w;
    logic [NBUF-1:0][TAG_W-1:0] tags_w;
    logic [NBUF-1:0][IDX_W-1:0] ages_w;
    logic                       hit_w;
    idx_t                       hit_idx_w;
    idx_t                       victim_w;
    logic                       act;
    logic                       touch_en;
    idx_t                       touch_idx;
    logic                       alloc_en;
    rsp_t                       rsp_q;

    assign cfg_new = cfg_e'(cfg_wdata);

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_3_1;
        else if (cfg_we) cfg_q <= cfg_new;
    end

    assign req_grp = grp_for_req(cfg_q, req_is_data);
    assign req_tag = req_addr[ADDR_W-1:OFF_W];

    lbuf_lookup #(.TAG_W(TAG_W)) u_lookup (
        .cfg     (cfg_q),
        .req_grp (req_grp),
        .req_tag (req_tag),
        .valid   (valid_w),
        .tags    (tags_w),
        .hit     (hit_w),
        .hit_idx (hit_idx_w)
    );

    // A configuration write takes priority over the state update of a request
    assign act       = req_valid && !cfg_we;
    assign alloc_en  = act && !hit_w;
    assign touch_en  = act && !req_prefetch;
    assign touch_idx = hit_w ? hit_idx_w : victim_w;

    lbuf_recency u_recency (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg_q),
        .reinit     (cfg_we),
        .reinit_cfg (cfg_new),
        .req_grp    (req_grp),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (victim_w),
        .ages_o     (ages_w)
    );

    lbuf_tags #(.TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg_we),
        .alloc_en  (alloc_en),
        .alloc_idx (victim_w),
        .fill_en   (fill_done),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .valid_o   (valid_w),
        .tag_o     (tags_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_q.hit        <= hit_w;
                rsp_q.hit_idx    <= hit_idx_w;
                rsp_q.victim_idx <= victim_w;
            end
        end
    end

    assign rsp_hit        = rsp_q.hit;
    assign rsp_hit_idx    = rsp_q.hit_idx;
    assign rsp_victim_idx = rsp_q.victim_idx;

endmodule

// File: rtl/lbuf_alloc_chk.sv
module lbuf_alloc_chk
    import lbuf_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       cfg_we,
    input logic                       req_valid,
    input logic                       req_is_data,
    input logic                       req_prefetch,
    input logic                       rsp_valid,
    input logic                       rsp_hit,
    input logic [1:0]                 rsp_hit_idx,
    input logic [1:0]                 rsp_victim_idx,
    input cfg_e                       cfg_q,
    input logic [NBUF-1:0]            valid_w,
    input logic [NBUF-1:0][IDX_W-1:0] ages_w
);

    logic ranks_ok;

    always_comb begin
        ranks_ok = 1'b1;
        for (int g = 0; g < 2; g++) begin
            logic [NBUF-1:0] seen;
            seen = '0;
            for (int b = 0; b < NBUF; b++)
                if (grp_of(cfg_q, idx_t'(b)) == logic'(g)) seen[ages_w[b]] = 1'b1;
            if (seen != NBUF'((1 << grp_size(cfg_q, logic'(g))) - 1)) ranks_ok = 1'b0;
        end
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R6
    AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R6
    AST_HIT_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_we) |=> (!rsp_hit ||
            grp_of($past(cfg_q), rsp_hit_idx) == grp_for_req($past(cfg_q), $past(req_is_data)))); // R7
    AST_VICTIM_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_we) |=> (rsp_hit ||
            grp_of($past(cfg_q), rsp_victim_idx) == grp_for_req($past(cfg_q), $past(req_is_data)))); // R8
    AST_VICTIM_INVALID: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_we) |=> (rsp_hit || !valid_w[rsp_victim_idx])); // R8
    AST_DEMAND_IS_MRU: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_prefetch && !cfg_we) |=>
            (ages_w[rsp_hit ? rsp_hit_idx : rsp_victim_idx] == '0)); // R9
    AST_RANKS_PERMUTE: assert property (@(posedge clk) disable iff (rst)
        ranks_ok); // R9
    AST_PREFETCH_KEEPS_ORDER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_prefetch && !cfg_we) |=> $stable(ages_w)); // R10
    AST_CFG_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (valid_w == '0)); // R12

endmodule

bind lbuf_alloc lbuf_alloc_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_we         (cfg_we),
    .req_valid      (req_valid),
    .req_is_data    (req_is_data),
    .req_prefetch   (req_prefetch),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_hit_idx    (rsp_hit_idx),
    .rsp_victim_idx (rsp_victim_idx),
    .cfg_q          (cfg_q),
    .valid_w        (valid_w),
    .ages_w         (ages_w)
);

// File: tb/lbuf_alloc_bench.sv
module lbuf_alloc_bench;

    localparam int ADDR_W = 32;
    localparam int OFF_W  = 4;
    localparam int TAG_W  = ADDR_W - OFF_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_wdata = 2'b00;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_is_data = 1'b0;
    logic              req_prefetch = 1'b0;
    logic              fill_done = 1'b0;
    logic [1:0]        fill_idx = 2'b00;
    logic [TAG_W-1:0]  fill_tag = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [1:0]        rsp_hit_idx;
    logic [1:0]        rsp_victim_idx;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_q[$];
    string      rq_q[$];

    always #5 clk = ~clk;

    lbuf_alloc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_lbuf_alloc (
        .clk            (clk),
        .rst            (rst),
        .cfg_we         (cfg_we),
        .cfg_wdata      (cfg_wdata),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_is_data    (req_is_data),
        .req_prefetch   (req_prefetch),
        .fill_done      (fill_done),
        .fill_idx       (fill_idx),
        .fill_tag       (fill_tag),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_hit_idx    (rsp_hit_idx),
        .rsp_victim_idx (rsp_victim_idx)
    );

    task automatic check(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Driver: one request, expected outcome goes to the scoreboard
    task automatic do_req(input logic is_data, input logic pf, input int tag,
                          input logic exp_hit, input int exp_idx, input string rq);
        @(negedge clk);
        req_valid    = 1'b1;
        req_is_data  = is_data;
        req_prefetch = pf;
        req_addr     = ADDR_W'(tag) << OFF_W;
        exp_q.push_back({exp_hit, 2'(exp_idx)});
        rq_q.push_back(rq);
        @(negedge clk);
        req_valid    = 1'b0;
        req_prefetch = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, {rq, " R6 idle after response"}, int'(rsp_valid), 0);
    endtask

    task automatic do_fill(input int idx, input int tag);
        @(negedge clk);
        fill_done = 1'b1;
        fill_idx  = 2'(idx);
        fill_tag  = TAG_W'(tag);
        @(negedge clk);
        fill_done = 1'b0;
    endtask

    task automatic do_cfg(input logic [1:0] code);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = code;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever a response appears
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected response", 1, 0);
            end else begin
                logic [2:0] e;
                string      rq;
                e  = exp_q.pop_front();
                rq = rq_q.pop_front();
                check(rsp_hit == e[2], {rq, " hit flag"}, int'(rsp_hit), int'(e[2]));
                if (e[2])
                    check(rsp_hit_idx == e[1:0], {rq, " hit index"}, int'(rsp_hit_idx), int'(e[1:0]));
                else
                    check(rsp_victim_idx == e[1:0], {rq, " victim index"},
                          int'(rsp_victim_idx), int'(e[1:0]));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);
        check(rsp_hit == 1'b0, "R1 reset rsp_hit", int'(rsp_hit), 0);

        // Default grouping 11: instr {0,1,2}, data {3}
        do_req(0, 0, 10, 0, 0, "R1 first instr miss");
        do_fill(0, 10);
        do_req(0, 0, 10, 1, 0, "R11 R7 instr hit after fill");
        do_req(1, 0, 20, 0, 3, "R1 R4 first data miss");
        do_fill(3, 20);
        do_req(1, 0, 20, 1, 3, "R4 data hit");
        do_req(1, 0, 10, 0, 3, "R7 R4 data misses on instr line");
        do_fill(3, 21);
        do_req(0, 0, 11, 0, 1, "R8 instr LRU victim");
        do_fill(1, 11);
        do_req(0, 1, 12, 0, 2, "R10 prefetch miss victim");
        do_fill(2, 12);
        do_req(0, 1, 12, 1, 2, "R10 prefetch hit");
        do_req(0, 0, 13, 0, 2, "R10 prefetched line left LRU");
        do_fill(2, 13);
        do_req(0, 0, 10, 1, 0, "R9 demand hit promotes");
        do_req(0, 0, 14, 0, 1, "R9 victim after promotion");
        do_fill(1, 14);
        do_req(0, 1, 15, 0, 2, "R10 second prefetch miss");
        do_fill(2, 15);
        do_req(0, 0, 15, 1, 2, "R10 demand hit on prefetched line");
        do_req(0, 0, 16, 0, 0, "R10 promotion moved LRU");

        // Shared pool
        do_cfg(2'b00);
        do_req(0, 0, 14, 0, 0, "R12 R2 flushed line misses");
        do_req(1, 0, 30, 0, 1, "R2 data shares pool");
        do_req(0, 0, 31, 0, 2, "R2 pool order 2");
        do_req(1, 0, 32, 0, 3, "R2 pool order 3");
        do_req(0, 0, 33, 0, 0, "R2 pool wraps");
        do_fill(0, 40);
        do_req(1, 0, 40, 1, 0, "R2 data hits instr fill");

        // Two pairs
        do_cfg(2'b10);
        do_req(0, 0, 41, 0, 0, "R3 R12 instr first");
        do_req(0, 0, 42, 0, 1, "R3 instr second");
        do_req(0, 0, 43, 0, 0, "R3 instr stays in pair");
        do_req(1, 0, 44, 0, 2, "R3 data first");
        do_req(1, 0, 45, 0, 3, "R3 data second");
        do_fill(3, 50);
        do_req(0, 0, 50, 0, 1, "R3 instr ignores data line");
        do_req(1, 0, 50, 1, 3, "R3 data hit");

        // Reserved code acts as pool
        do_cfg(2'b01);
        do_req(0, 0, 51, 0, 0, "R5 reserved instr");
        do_req(1, 0, 52, 0, 1, "R5 reserved data uses shared order");
        do_req(1, 0, 53, 0, 2, "R5 reserved data next");

        do_cfg(2'b11);
        do_req(1, 0, 54, 0, 3, "R4 R12 data after rewrite");
        do_req(0, 0, 55, 0, 0, "R4 R12 instr after rewrite");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 all responses seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule